// File: doc/BRIEF.md
# DAC Conversion Trigger and Data Controller

This block is the digital side of a 12-bit digital-to-analog converter. Software writes a 32-bit data register. At the moment a conversion is accepted, the block takes 12 bits from that register, either right justified or left justified within the low half-word. It then hands the value to the analog core together with a one-cycle start strobe.

Only one start source is active at a time. With triggering off, the start source is a data write. With triggering on, it is one of the following:
- a self-clearing software strobe;
- an external pin, qualified by low level, high level, falling edge or rising edge;
- one of four timer pulses;
- one of two PWM pulses.

A busy flag covers a programmable settle time. A finish flag is raised when busy drops. Hardware-sourced starts can raise a DMA request for the next sample. A hardware start that arrives while the previous request is still unanswered is recorded as an under-run. Both flags are cleared by writing 1 to them, and either flag can drive the interrupt line.

Top module: `dac_trig_ctrl`

Register map:

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit0 trigger enable, bit1 finish interrupt enable, bit2 DMA enable, bit3 under-run interrupt enable, bit4 left align, bits[7:5] source select, bits[9:8] pin mode, bits[23:16] settle count. All other bits read 0. |
| 1 | DATA | 32-bit data register. |
| 2 | SWSTRB | Software strobe, bit0. |
| 3 | STATUS | bit0 finish, bit1 under-run, bit8 busy. |

## Requirements
- R1: With CTRL bit4 = 1 (left align), the converted value is DATA[15:4]. All other DATA bits have no effect on it.
- R2: With CTRL bit4 = 0 (right align), the converted value is DATA[11:0]. DATA[31:12] have no effect on it.
- R3: With CTRL bit0 = 0, a write to DATA starts a conversion on that clock edge, and that conversion converts the newly written value. With CTRL bit0 = 1, a DATA write does not start a conversion; instead CTRL[7:5] selects the source: 0 software, 1 pin, 2..5 timers 0..3, 6..7 PWM 0..1. A timer or PWM pulse that is high at an edge starts a conversion on that edge.
- R4: The pin passes through two synchronizer flops. CTRL[9:8] selects the pin condition: 0 low level, 1 high level, 2 falling edge, 3 rising edge. A pin change seen at edge k starts a conversion at edge k+2.
- R5: Writing 1 to SWSTRB bit0 sets that bit for exactly one cycle, and that pulse starts a conversion at the following edge. Writing 0 does nothing.
- R6: When CTRL bit2 = 1, an accepted start from a source with CTRL[7:5] not equal to 0 (and CTRL bit0 = 1) sets dma_req. A DATA write clears dma_req. If both occur on the same edge, the set wins.
- R7: A DMA-requesting start that arrives while dma_req is already set, with no DATA write on that edge, sets the under-run flag (STATUS bit1).
- R8: An accepted start raises conv_start for one cycle and raises busy. Busy stays high for settle+1 cycles. The finish flag (STATUS bit0) is set on the edge at which busy falls.
- R9: Writing 1 to STATUS bit0 clears finish, and writing 1 to STATUS bit1 clears under-run. A new set on the same edge wins. Writing 0 leaves the flag unchanged.
- R10: irq equals (finish and CTRL bit1) or (under-run and CTRL bit3).
- R11: Starts that arrive while busy is high are ignored. conv_data changes only at an accepted start, when it takes the value being converted.
- R12: After reset, every output and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 CTRL, 1 DATA, 2 SWSTRB, 3 STATUS) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from the registers |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_trig | input | 4 | Timer trigger pulses |
| pwm_trig | input | 2 | PWM trigger pulses |
| conv_start | output | 1 | One-cycle conversion start to the analog core |
| conv_data | output | 12 | Held value under conversion |
| dac_busy | output | 1 | Conversion in progress |
| dma_req | output | 1 | Request for new data |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach is an under-run. It needs DMA enabled, a hardware source selected, one accepted start whose request is left unanswered, and then a second accepted start after busy has dropped. Busy must have dropped first because the second start would otherwise be ignored.

A directed sequence therefore sets a short settle count and pulses the selected timer twice, with no DATA write in between. A long randomized phase then keeps the settle count small and writes CTRL often, so that source switches, edge and level pin modes, and same-edge set/clear collisions keep occurring. A per-clock behavioural model checks every output, including the readback, in every cycle.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
   localparam int ADDR_W     = 2;
   localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
   localparam logic [ADDR_W-1:0] A_DATA   = 2'd1;
   localparam logic [ADDR_W-1:0] A_SWSTRB = 2'd2;
   localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

   // control field positions
   localparam int B_TRIG_EN  = 0;
   localparam int B_FIN_IE   = 1;
   localparam int B_DMA_EN   = 2;
   localparam int B_UDR_IE   = 3;
   localparam int B_LEFT     = 4;
   localparam int F_SEL_LSB  = 5;
   localparam int SEL_W      = 3;
   localparam int F_PM_LSB   = 8;
   localparam int F_SET_LSB  = 16;

   // status field positions
   localparam int S_FIN  = 0;
   localparam int S_UDR  = 1;
   localparam int S_BUSY = 8;

   typedef enum logic [1:0] {
      PM_LOW  = 2'd0,
      PM_HIGH = 2'd1,
      PM_FALL = 2'd2,
      PM_RISE = 2'd3
   } pin_mode_e;
endpackage

// File: rtl/dac_pin_cond.sv
module dac_pin_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] mode,
   output logic       hit
);
   import dac_trig_pkg::*;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("dac_pin_cond: SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pin;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
         end
      end
   endgenerate

   assign cur = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;

   always_comb begin
      unique case (pin_mode_e'(mode))
         PM_LOW:  hit = ~cur;
         PM_HIGH: hit = cur;
         PM_FALL: hit = prev_q & ~cur;
         PM_RISE: hit = ~prev_q & cur;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
   parameter int NUM_TMR = 4,
   parameter int NUM_PWM = 2,
   parameter int SEL_W   = 3
) (
   input  logic               trig_en,
   input  logic [SEL_W-1:0]   sel,
   input  logic               data_wr,
   input  logic               sw_pulse,
   input  logic               pin_hit,
   input  logic [NUM_TMR-1:0] tmr,
   input  logic [NUM_PWM-1:0] pwm,
   output logic               evt,
   output logic               hw_src
);
   localparam int TMR_BASE = 2;
   localparam int PWM_BASE = TMR_BASE + NUM_TMR;

   generate
      if (PWM_BASE + NUM_PWM > (1 << SEL_W)) begin : g_bad
         $error("dac_trig_sel: sources do not fit the select field");
      end
   endgenerate

   always_comb begin
      evt    = 1'b0;
      hw_src = 1'b0;
      if (!trig_en) begin
         evt = data_wr;
      end else begin
         hw_src = (sel != '0);
         if (sel == SEL_W'(0)) evt = sw_pulse;
         if (sel == SEL_W'(1)) evt = pin_hit;
         for (int i = 0; i < NUM_TMR; i++)
            if (sel == SEL_W'(TMR_BASE + i)) evt = tmr[i];
         for (int j = 0; j < NUM_PWM; j++)
            if (sel == SEL_W'(PWM_BASE + j)) evt = pwm[j];
      end
   end
endmodule

// File: rtl/dac_conv_seq.sv
module dac_conv_seq #(
   parameter int DATA_W   = 12,
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt,
   input  logic [SETTLE_W-1:0] settle,
   input  logic [DATA_W-1:0]   value,
   output logic                accept,
   output logic                done,
   output logic                start_q,
   output logic                busy_q,
   output logic [DATA_W-1:0]   hold_q
);
   logic [SETTLE_W-1:0] cnt_q;

   assign accept = evt & ~busy_q;
   assign done   = busy_q & (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         cnt_q   <= '0;
         hold_q  <= '0;
      end else begin
         start_q <= accept;
         if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= settle;
            hold_q <= value;
         end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl #(
   parameter int BUS_W       = 32,
   parameter int DATA_W      = 12,
   parameter int SETTLE_W    = 8,
   parameter int NUM_TMR     = 4,
   parameter int NUM_PWM     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [BUS_W-1:0]   wr_data,
   input  logic [1:0]         rd_addr,
   output logic [BUS_W-1:0]   rd_data,
   input  logic               ext_pin,
   input  logic [NUM_TMR-1:0] tmr_trig,
   input  logic [NUM_PWM-1:0] pwm_trig,
   output logic               conv_start,
   output logic [DATA_W-1:0]  conv_data,
   output logic               dac_busy,
   output logic               dma_req,
   output logic               irq
);
   import dac_trig_pkg::*;

   localparam int LEFT_LSB = 16 - DATA_W;

   generate
      if (DATA_W > 16 || DATA_W < 1) begin : g_bad_w
         $error("dac_trig_ctrl: DATA_W must be 1..16");
      end
      if (BUS_W < F_SET_LSB + SETTLE_W) begin : g_bad_bus
         $error("dac_trig_ctrl: BUS_W too narrow for control fields");
      end
   endgenerate

   logic               trig_en_q, fin_ie_q, dma_en_q, udr_ie_q, left_q;
   logic [SEL_W-1:0]   sel_q;
   logic [1:0]         pmode_q;
   logic [SETTLE_W-1:0] settle_q;
   logic [BUS_W-1:0]   data_q;
   logic               sw_q, fin_q, udr_q, req_q;

   logic wr_ctrl, wr_dat, wr_sw, wr_st;
   logic pin_hit, evt, hw_src, accept, done;
   logic [BUS_W-1:0]  next_dat;
   logic [DATA_W-1:0] extracted;
   logic dma_start;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign wr_dat  = wr_en && (wr_addr == A_DATA);
   assign wr_sw   = wr_en && (wr_addr == A_SWSTRB) && wr_data[0];
   assign wr_st   = wr_en && (wr_addr == A_STATUS);

   dac_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin), .mode(pmode_q), .hit(pin_hit)
   );

   dac_trig_sel #(.NUM_TMR(NUM_TMR), .NUM_PWM(NUM_PWM), .SEL_W(SEL_W)) sel_i (
      .trig_en(trig_en_q), .sel(sel_q), .data_wr(wr_dat), .sw_pulse(sw_q),
      .pin_hit(pin_hit), .tmr(tmr_trig), .pwm(pwm_trig),
      .evt(evt), .hw_src(hw_src)
   );

   // a data write that starts a conversion converts the new value
   assign next_dat  = wr_dat ? wr_data : data_q;
   assign extracted = left_q ? next_dat[LEFT_LSB +: DATA_W] : next_dat[0 +: DATA_W];

   dac_conv_seq #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .evt(evt), .settle(settle_q), .value(extracted),
      .accept(accept), .done(done), .start_q(conv_start), .busy_q(dac_busy),
      .hold_q(conv_data)
   );

   assign dma_start = accept && hw_src && dma_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_en_q <= 1'b0; fin_ie_q <= 1'b0; dma_en_q <= 1'b0;
         udr_ie_q  <= 1'b0; left_q   <= 1'b0;
         sel_q     <= '0;   pmode_q  <= '0;   settle_q <= '0;
         data_q    <= '0;   sw_q     <= 1'b0;
         fin_q     <= 1'b0; udr_q    <= 1'b0; req_q    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            trig_en_q <= wr_data[B_TRIG_EN];
            fin_ie_q  <= wr_data[B_FIN_IE];
            dma_en_q  <= wr_data[B_DMA_EN];
            udr_ie_q  <= wr_data[B_UDR_IE];
            left_q    <= wr_data[B_LEFT];
            sel_q     <= wr_data[F_SEL_LSB +: SEL_W];
            pmode_q   <= wr_data[F_PM_LSB +: 2];
            settle_q  <= wr_data[F_SET_LSB +: SETTLE_W];
         end
         if (wr_dat) data_q <= wr_data;
         sw_q  <= wr_sw;
         fin_q <= done | (fin_q & ~(wr_st & wr_data[S_FIN]));
         udr_q <= (dma_start & req_q & ~wr_dat) | (udr_q & ~(wr_st & wr_data[S_UDR]));
         req_q <= dma_start | (req_q & ~wr_dat);
      end
   end

   assign dma_req = req_q;
   assign irq     = (fin_q & fin_ie_q) | (udr_q & udr_ie_q);

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL: begin
            rd_data[B_TRIG_EN] = trig_en_q;
            rd_data[B_FIN_IE]  = fin_ie_q;
            rd_data[B_DMA_EN]  = dma_en_q;
            rd_data[B_UDR_IE]  = udr_ie_q;
            rd_data[B_LEFT]    = left_q;
            rd_data[F_SEL_LSB +: SEL_W]    = sel_q;
            rd_data[F_PM_LSB +: 2]         = pmode_q;
            rd_data[F_SET_LSB +: SETTLE_W] = settle_q;
         end
         A_DATA:   rd_data = data_q;
         A_SWSTRB: rd_data[0] = sw_q;
         default: begin
            rd_data[S_FIN]  = fin_q;
            rd_data[S_UDR]  = udr_q;
            rd_data[S_BUSY] = dac_busy;
         end
      endcase
   end
endmodule

// File: rtl/dac_trig_ctrl_chk.sv
module dac_trig_ctrl_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_start,
   input logic              busy,
   input logic              finish,
   input logic              udr,
   input logic              dma_req,
   input logic              irq,
   input logic [DATA_W-1:0] conv_data
);
   a_r8_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   a_r11_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> !$past(busy));

   a_r8_finish_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> finish);

   a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_start |-> $stable(conv_data));

   a_r7_udr_needs_pending_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(udr) |-> $past(dma_req));

   a_r6_req_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req) |-> conv_start);

   a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (finish || udr));
endmodule

bind dac_trig_ctrl dac_trig_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .busy(dac_busy),
   .finish(fin_q), .udr(udr_q), .dma_req(dma_req), .irq(irq),
   .conv_data(conv_data)
);

// File: tb/dac_trig_ctrl_tb.sv
module dac_trig_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [1:0]  rd_addr = 2'd0;
   logic [31:0] rd_data;
   logic        ext_pin = 1'b0;
   logic [3:0]  tmr_trig = 4'd0;
   logic [1:0]  pwm_trig = 2'd0;
   logic        conv_start, dac_busy, dma_req, irq;
   logic [11:0] conv_data;

   int checks = 0;
   int failures = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;   // 50 MHz

   dac_trig_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ext_pin(ext_pin), .tmr_trig(tmr_trig), .pwm_trig(pwm_trig),
      .conv_start(conv_start), .conv_data(conv_data), .dac_busy(dac_busy),
      .dma_req(dma_req), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_ctrl, m_data;
   logic        m_sw, m_s1, m_s2, m_pd;
   logic        m_busy, m_fin, m_udr, m_req, m_start;
   int          m_cnt;
   logic [11:0] m_hold;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_data = 0; m_sw = 0; m_s1 = 0; m_s2 = 0; m_pd = 0;
         m_busy = 0; m_fin = 0; m_udr = 0; m_req = 0; m_start = 0;
         m_cnt = 0; m_hold = 0;
      end else begin
         bit dw, cw, sw, stw, evt, st, hw, done, dmas;
         int sel;
         logic [31:0] nd;
         dw  = wr_en && wr_addr == 2'd1;
         cw  = wr_en && wr_addr == 2'd0;
         sw  = wr_en && wr_addr == 2'd2 && wr_data[0];
         stw = wr_en && wr_addr == 2'd3;
         sel = int'(m_ctrl[7:5]);
         evt = 0;
         if (!m_ctrl[0]) evt = dw;
         else if (sel == 0) evt = m_sw;
         else if (sel == 1) begin
            case (m_ctrl[9:8])
               2'd0: evt = !m_s2;
               2'd1: evt = m_s2;
               2'd2: evt = m_pd && !m_s2;
               default: evt = !m_pd && m_s2;
            endcase
         end
         else if (sel <= 5) evt = tmr_trig[sel-2];
         else evt = pwm_trig[sel-6];
         st   = evt && !m_busy;
         hw   = m_ctrl[0] && sel != 0;
         dmas = st && hw && m_ctrl[2];
         done = m_busy && m_cnt == 0;
         nd   = dw ? wr_data : m_data;
         m_fin = done || (m_fin && !(stw && wr_data[0]));
         m_udr = (dmas && m_req && !dw) || (m_udr && !(stw && wr_data[1]));
         m_req = dmas || (m_req && !dw);
         if (st) begin
            m_busy = 1; m_cnt = int'(m_ctrl[23:16]);
            m_hold = m_ctrl[4] ? nd[15:4] : nd[11:0];
         end else if (m_busy) begin
            if (m_cnt == 0) m_busy = 0; else m_cnt = m_cnt - 1;
         end
         m_start = st;
         if (cw) m_ctrl = wr_data & 32'h00FF_03FF;
         if (dw) m_data = wr_data;
         m_sw = sw;
         m_pd = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
      end
   end

   task automatic cmp(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s t=%0t actual=%h expected=%h", tag, nm, $time, act, exp);
      end
   endtask

   // per-cycle comparison, mid high phase
   always @(posedge clk) begin
      #5;
      if (rst_n && !done_flag) begin
         logic [31:0] er;
         logic        ei;
         cmp("R8", "conv_start", 32'(conv_start), 32'(m_start));
         cmp("R8", "dac_busy", 32'(dac_busy), 32'(m_busy));
         cmp("R11", "conv_data", 32'(conv_data), 32'(m_hold));
         cmp("R6", "dma_req", 32'(dma_req), 32'(m_req));
         ei = (m_fin && m_ctrl[1]) || (m_udr && m_ctrl[3]);
         cmp("R10", "irq", 32'(irq), 32'(ei));
         case (rd_addr)
            2'd0: er = m_ctrl;
            2'd1: er = m_data;
            2'd2: er = {31'd0, m_sw};
            default: er = {23'd0, m_busy, 6'd0, m_udr, m_fin};
         endcase
         cmp("R9", "rd_data", rd_data, er);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      rd_addr = a;
      #1;
      cmp(tag, "readback", rd_data, exp);
   endtask

   task automatic pulse_tmr(input int i);
      @(negedge clk);
      tmr_trig[i] = 1;
      @(negedge clk);
      tmr_trig[i] = 0;
   endtask

   initial begin
      #(20 * 190000);
      failures++;
      $display("FAIL watchdog expired");
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1;
      #1;
      // R12 reset state
      cmp("R12", "conv_data", 32'(conv_data), 0);
      cmp("R12", "dac_busy", 32'(dac_busy), 0);
      cmp("R12", "irq_dma", {30'd0, irq, dma_req}, 0);
      rd_chk(2'd3, 0, "R12");
      rd_chk(2'd0, 0, "R12");

      // R2 right align, R3 data-write start, R8 busy/finish
      wr(2'd0, 32'h0002_0000);
      wr(2'd1, 32'hABCD_5123);
      cmp("R2", "conv_data", 32'(conv_data), 32'h123);
      cmp("R8", "busy_after_start", 32'(dac_busy), 1);
      idle(4);
      rd_chk(2'd3, 32'h1, "R8");
      wr(2'd3, 32'h1);
      rd_chk(2'd3, 32'h0, "R9");

      // R1 left align
      wr(2'd0, 32'h0002_0010);
      wr(2'd1, 32'h0000_ABCD);
      cmp("R1", "conv_data", 32'(conv_data), 32'hABC);
      idle(4);

      // R11 write while busy is ignored
      wr(2'd0, 32'h0014_0010);
      wr(2'd1, 32'h0000_1110);
      wr(2'd1, 32'h0000_2220);
      cmp("R11", "conv_data", 32'(conv_data), 32'h111);
      idle(25);
      rd_chk(2'd1, 32'h2220, "R11");

      // R5 software strobe, R3 data write without start when triggering on
      wr(2'd0, 32'h0001_0001);
      wr(2'd1, 32'h0000_0456);
      idle(2);
      cmp("R3", "no_start_on_write", 32'(conv_data), 32'h111);
      wr(2'd2, 32'h1);
      idle(1);
      cmp("R5", "conv_data", 32'(conv_data), 32'h456);
      wr(2'd3, 32'h1);

      // R4 pin rising edge
      wr(2'd1, 32'h0000_0789);
      wr(2'd0, 32'h0001_0321);
      idle(3);
      @(negedge clk) ext_pin = 1;
      idle(4);
      cmp("R4", "conv_data", 32'(conv_data), 32'h789);
      idle(3);
      @(negedge clk) ext_pin = 0;

      // R6 DMA on timer 2, R7 under-run, R10 irq, R9 W1C
      wr(2'd1, 32'h0000_0321);
      wr(2'd0, 32'h0001_008D);
      pulse_tmr(2);
      cmp("R6", "dma_req", 32'(dma_req), 1);
      cmp("R3", "conv_data", 32'(conv_data), 32'h321);
      idle(4);
      pulse_tmr(2);
      idle(4);
      rd_chk(2'd3, 32'h3, "R7");
      cmp("R10", "irq", 32'(irq), 1);
      wr(2'd3, 32'h2);
      wr(2'd0, 32'h0001_0089);
      rd_chk(2'd3, 32'h1, "R9");
      wr(2'd3, 32'h1);
      cmp("R10", "irq_clear", 32'(irq), 0);
      wr(2'd1, 32'h0);
      cmp("R6", "dma_req_cleared", 32'(dma_req), 0);

      // randomized phase, compared each cycle against the model
      for (int c = 0; c < 6000; c++) begin
         @(negedge clk);
         rd_addr  = 2'($urandom_range(0, 3));
         tmr_trig = 4'($urandom) & 4'($urandom);
         pwm_trig = 2'($urandom) & 2'($urandom);
         if ($urandom_range(0, 7) == 0) ext_pin = ~ext_pin;
         wr_en = ($urandom_range(0, 3) == 0);
         wr_addr = 2'($urandom_range(0, 3));
         wr_data = $urandom;
         if (wr_addr == 2'd0) wr_data[23:16] = 8'($urandom_range(0, 4));
         if (wr_addr == 2'd0 && $urandom_range(0, 2) != 0) wr_en = 0;
      end
      @(negedge clk) wr_en = 0;
      idle(3);
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule